// File: doc/BRIEF.md
# Slot-Owned Serial Transmitter with Destination Lane

This block drives one station's share of a shared time-division serial bus that carries two serial lines side by side: a data line and a destination line. An external bus master supplies the bit clock, which is also the block's clock, and a one-cycle frame pulse. After each frame pulse the block counts fixed 16-bit time slots. In every slot that its slot-enable mask selects, it shifts a data word out on the data line. At the same time it shifts a destination bitmask out on the destination line. A receiver reads each set bit of that mask as "this word is for me", so one slot can reach several receivers. In every other slot, and between frames, both lines are released: the output enables drop and the output values are held at zero.

Words are fetched just in time. One slot ahead of each owned slot, the block raises a request naming that slot. A producer answers with a data and mask pair. If no pair has arrived when the slot opens, zeros are sent and a sticky underrun flag is raised. A frame pulse that arrives while the current frame still has more bits left than the lead-in delay leaves time for is a framing error. So is a pulse during the lead-in delay itself. In either case the running frame is dropped, the slot counter restarts at slot 0, and a sticky flag is raised.

Top module: `tdm_addr_slot_tx`

## Requirements
- R1: After a frame pulse sampled on rising edge k, the most significant bit of slot 0 is on the lines after edge k+1 when `cfg_lead_i` is 0 and after edge k+2 when it is 1. Each slot then holds 16 bits, most significant bit first, one bit per clock. Slots follow each other with no gap.
- R2: The destination line shifts the 16-bit mask that was loaded with the data word, bit for bit in lockstep with the data line, and its enable matches the data enable in every cycle.
- R3: Bit s of `slot_en_i` makes slot s an owned slot. Both enables are high for exactly the 16 bits of owned slots and low otherwise. While an enable is low, its output value is 0.
- R4: A frame has `cfg_slots_i` slots. A value of 0 counts as 1, and values above 8 count as 8. After the last slot, both lines stay released until the next frame pulse.
- R5: An output enable changes only on the edge that puts out the first bit of a slot, or on the edge right after a slot's last bit when no owned slot follows.
- R6: For each owned slot s, `req_o` rises with `req_slot_o` = s. For slot 0 this happens on the frame-pulse edge; for a later slot, on the edge that opens slot s-1. A pair is taken on an edge where `req_o` and `ld_valid_i` are both high, and `req_o` then falls. A pair taken on the edge that opens its slot is sent in that slot.
- R7: If an owned slot opens with no pair taken, both lines send 16 zeros with their enables high, and `underrun_o` rises and stays high until reset.
- R8: A frame pulse is a framing error when it arrives during the lead-in delay, or while the running frame still has more bits left to send than the lead-in length. On a framing error `frame_err_o` rises and stays high until reset, both lines are released on that edge, and slot 0 of the new frame starts after the usual lead-in.
- R9: Frame pulses spaced exactly 16 times the slot count apart run frame after frame with no gap and no framing error, for both lead-in settings.
- R10: While reset is high, all enables, line values, `req_o` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frm_i | input | 1 | One-cycle frame pulse from the bus master |
| cfg_lead_i | input | 1 | Lead-in: 0 gives one bit clock, 1 gives two |
| cfg_slots_i | input | 4 | Slots per frame (0 counts as 1, above 8 as 8) |
| slot_en_i | input | 8 | Owned-slot mask; bit s stands for slot s |
| req_o | output | 1 | A word pair is wanted for slot `req_slot_o` |
| req_slot_o | output | 3 | Slot index of the pending request |
| ld_valid_i | input | 1 | Pair on `ld_data_i`/`ld_addr_i` is offered |
| ld_data_i | input | 16 | Data word for the requested slot |
| ld_addr_i | input | 16 | Destination bitmask for the requested slot |
| dat_o | output | 1 | Data line value |
| dat_oe_o | output | 1 | Data line drive enable |
| adr_o | output | 1 | Destination line value |
| adr_oe_o | output | 1 | Destination line drive enable |
| underrun_o | output | 1 | Sticky: an owned slot opened without a word |
| frame_err_o | output | 1 | Sticky: a frame pulse arrived out of place |

## Verification
The bench builds the block with 16-bit slots and up to 8 slots per frame. With these values a full 8-slot frame fits in 128 clocks, so frames at full length, frames clamped from an over-range slot count, and single-slot frames can all run many times within the cycle limit. The same settings make both lead-in lengths reachable, and with them the boundary where a pulse counts as on time versus mid-frame. The bench covers the edge cases on both sides of that line: a pulse exactly one frame period after the last, one that lands in the middle of a slot, and one that lands during the lead-in.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int LANE_DAT  = 0;
    localparam int LANE_ADR  = 1;
    localparam int NUM_LANES = 2;

    typedef enum logic {
        LEAD_ONE = 1'b0,
        LEAD_TWO = 1'b1
    } lead_e;

    typedef struct packed {
        logic open;   // a slot starts on this edge
        logic close;  // the frame ends or is aborted on this edge
        logic fault;  // frame pulse out of place
    } slot_evt_t;

    function automatic int lead_bits(lead_e l);
        return (l == LEAD_TWO) ? 2 : 1;
    endfunction

    function automatic int last_slot(int cfg, int max_slots);
        if (cfg <= 0) return 0;
        if (cfg >= max_slots) return max_slots - 1;
        return cfg - 1;
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_BITS = 16,
    parameter int MAX_SLOTS = 8,
    localparam int SW = $clog2(MAX_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frm_i,
    input  lead_e         lead_i,
    input  logic [SW-1:0] last_i,
    output slot_evt_t     evt_o,
    output logic [SW-1:0] idx_o,
    output logic          ferr_o
);
    localparam int OW = $clog2(SLOT_BITS);
    localparam logic [OW-1:0] OFF_MAX = OW'(SLOT_BITS - 1);

    logic          armed_q;
    logic          wait_q;
    logic          run_q;
    logic [SW-1:0] slot_q;
    logic [OW-1:0] off_q;
    logic          ferr_q;

    logic at_end, start0, on_time, fault, advance;
    int   lead;

    always_comb begin
        lead    = lead_bits(lead_i);
        at_end  = run_q && (off_q == OFF_MAX);
        start0  = armed_q && !wait_q;
        on_time = !armed_q &&
                  (!run_q || ((slot_q == last_i) && (int'(off_q) >= SLOT_BITS - 1 - lead)));
        fault   = frm_i && !on_time;
        advance = at_end && (slot_q != last_i);
        evt_o.open  = !frm_i && (start0 || advance);
        evt_o.close = fault || (at_end && (slot_q == last_i));
        evt_o.fault = fault;
        idx_o = start0 ? '0 : SW'(slot_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            wait_q  <= 1'b0;
            run_q   <= 1'b0;
            slot_q  <= '0;
            off_q   <= '0;
            ferr_q  <= 1'b0;
        end else begin
            if (run_q) begin
                if (at_end) begin
                    if (slot_q == last_i) begin
                        run_q <= 1'b0;
                    end else begin
                        slot_q <= SW'(slot_q + 1'b1);
                        off_q  <= '0;
                    end
                end else begin
                    off_q <= OW'(off_q + 1'b1);
                end
            end
            if (armed_q && wait_q) wait_q <= 1'b0;
            if (frm_i) begin
                armed_q <= 1'b1;
                wait_q  <= (lead_i == LEAD_TWO);
                if (fault) begin
                    run_q  <= 1'b0;
                    ferr_q <= 1'b1;
                end
            end else if (start0) begin
                armed_q <= 1'b0;
                run_q   <= 1'b1;
                slot_q  <= '0;
                off_q   <= '0;
            end
        end
    end

    assign ferr_o = ferr_q;

    AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (slot_q <= last_i)); // R4
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(ferr_q) |-> ferr_q); // R8
    AST_FAULT_DROPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (frm_i && !on_time) |=> !run_q); // R8

endmodule

// File: rtl/tdm_word_buffer.sv
module tdm_word_buffer
    import tdm_tx_pkg::*;
#(
    parameter int W = 16,
    parameter int MAX_SLOTS = 8,
    localparam int SW = $clog2(MAX_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frm_i,
    input  logic                          open_i,
    input  logic [SW-1:0]                 idx_i,
    input  logic [SW-1:0]                 last_i,
    input  logic [MAX_SLOTS-1:0]          slot_en_i,
    input  logic                          ld_valid_i,
    input  logic [W-1:0]                  ld_data_i,
    input  logic [W-1:0]                  ld_addr_i,
    output logic                          req_o,
    output logic [SW-1:0]                 req_slot_o,
    output logic [NUM_LANES-1:0][W-1:0]   word_o,
    output logic                          under_o
);
    logic                         req_q;
    logic [SW-1:0]                rslot_q;
    logic                         full_q;
    logic [NUM_LANES-1:0][W-1:0]  hold_q;
    logic                         under_q;

    logic                         accept, en_cur, en_nxt, has_nxt, starve;
    logic [SW-1:0]                nxt;
    logic [NUM_LANES-1:0][W-1:0]  offered;

    always_comb begin
        offered[LANE_DAT] = ld_data_i;
        offered[LANE_ADR] = ld_addr_i;
        accept  = req_q && ld_valid_i && !frm_i;
        nxt     = SW'(idx_i + 1'b1);
        has_nxt = (idx_i != last_i);
        en_cur  = slot_en_i[idx_i];
        en_nxt  = has_nxt && slot_en_i[nxt];
        starve  = open_i && en_cur && !full_q && !accept;
        if (full_q)      word_o = hold_q;
        else if (accept) word_o = offered;
        else             word_o = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            rslot_q <= '0;
            full_q  <= 1'b0;
            hold_q  <= '0;
            under_q <= 1'b0;
        end else if (frm_i) begin
            req_q   <= slot_en_i[0];
            rslot_q <= '0;
            full_q  <= 1'b0;
        end else if (open_i) begin
            full_q  <= 1'b0;
            req_q   <= en_nxt;
            rslot_q <= nxt;
            if (starve) under_q <= 1'b1;
        end else if (accept) begin
            hold_q <= offered;
            full_q <= 1'b1;
            req_q  <= 1'b0;
        end
    end

    assign req_o      = req_q;
    assign req_slot_o = rslot_q;
    assign under_o    = under_q;

    AST_REQ_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> $past(frm_i || open_i)); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        full_q |-> !req_q); // R6
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(under_q) |-> under_q); // R7

endmodule

// File: rtl/tdm_lane_shifter.sv
module tdm_lane_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         open_i,
    input  logic         close_i,
    input  logic         own_i,
    input  logic [W-1:0] word_i,
    output logic         bit_o,
    output logic         oe_o
);
    logic [W-2:0] sh_q;
    logic         bit_q;
    logic         oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (open_i) begin
            oe_q  <= own_i;
            bit_q <= word_i[W-1];
            sh_q  <= word_i[W-2:0];
        end else if (close_i) begin
            oe_q  <= 1'b0;
            bit_q <= 1'b0;
            sh_q  <= '0;
        end else begin
            bit_q <= sh_q[W-2];
            sh_q  <= {sh_q[W-3:0], 1'b0};
        end
    end

    assign bit_o = bit_q;
    assign oe_o  = oe_q;

    AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !oe_q |-> !bit_q); // R3
    AST_OE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (oe_q != $past(oe_q)) |-> $past(open_i || close_i)); // R5

endmodule

// File: rtl/tdm_addr_slot_tx.sv
module tdm_addr_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_BITS = 16,
    parameter int MAX_SLOTS = 8,
    localparam int SW = $clog2(MAX_SLOTS),
    localparam int CW = $clog2(MAX_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frm_i,
    input  logic                 cfg_lead_i,
    input  logic [CW-1:0]        cfg_slots_i,
    input  logic [MAX_SLOTS-1:0] slot_en_i,
    output logic                 req_o,
    output logic [SW-1:0]        req_slot_o,
    input  logic                 ld_valid_i,
    input  logic [SLOT_BITS-1:0] ld_data_i,
    input  logic [SLOT_BITS-1:0] ld_addr_i,
    output logic                 dat_o,
    output logic                 dat_oe_o,
    output logic                 adr_o,
    output logic                 adr_oe_o,
    output logic                 underrun_o,
    output logic                 frame_err_o
);
    slot_evt_t                           evt;
    logic [SW-1:0]                       idx;
    logic [SW-1:0]                       last;
    logic [NUM_LANES-1:0][SLOT_BITS-1:0] words;
    logic [NUM_LANES-1:0]                bits;
    logic [NUM_LANES-1:0]                oes;
    logic                                own;

    assign last = SW'(last_slot(int'(cfg_slots_i), MAX_SLOTS));
    assign own  = slot_en_i[idx];

    tdm_slot_timer #(.SLOT_BITS(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .frm_i  (frm_i),
        .lead_i (lead_e'(cfg_lead_i)),
        .last_i (last),
        .evt_o  (evt),
        .idx_o  (idx),
        .ferr_o (frame_err_o)
    );

    tdm_word_buffer #(.W(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS)) u_buffer (
        .clk        (clk),
        .rst        (rst),
        .frm_i      (frm_i),
        .open_i     (evt.open),
        .idx_i      (idx),
        .last_i     (last),
        .slot_en_i  (slot_en_i),
        .ld_valid_i (ld_valid_i),
        .ld_data_i  (ld_data_i),
        .ld_addr_i  (ld_addr_i),
        .req_o      (req_o),
        .req_slot_o (req_slot_o),
        .word_o     (words),
        .under_o    (underrun_o)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        tdm_lane_shifter #(.W(SLOT_BITS)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .open_i  (evt.open),
            .close_i (evt.close),
            .own_i   (own),
            .word_i  (words[g]),
            .bit_o   (bits[g]),
            .oe_o    (oes[g])
        );
    end

    assign dat_o    = bits[LANE_DAT];
    assign dat_oe_o = oes[LANE_DAT];
    assign adr_o    = bits[LANE_ADR];
    assign adr_oe_o = oes[LANE_ADR];

    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        dat_oe_o == adr_oe_o); // R2
    AST_FAULT_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err_o) |-> (!dat_oe_o && !adr_oe_o)); // R8

endmodule

// File: tb/test_tdm_addr_slot_tx.sv
module test_tdm_addr_slot_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_i = 1'b0;
    logic        cfg_lead_i = 1'b0;
    logic [3:0]  cfg_slots_i = 4'd4;
    logic [7:0]  slot_en_i = 8'h00;
    logic        req_o;
    logic [2:0]  req_slot_o;
    logic        ld_valid_i = 1'b0;
    logic [15:0] ld_data_i = 16'h0;
    logic [15:0] ld_addr_i = 16'h0;
    logic        dat_o, dat_oe_o, adr_o, adr_oe_o, underrun_o, frame_err_o;

    int checks = 0;
    int errors = 0;
    int frame_id = 0;
    bit auto_load = 1'b1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tdm_addr_slot_tx i_tdm_addr_slot_tx (
        .clk(clk), .rst(rst), .frm_i(frm_i), .cfg_lead_i(cfg_lead_i),
        .cfg_slots_i(cfg_slots_i), .slot_en_i(slot_en_i),
        .req_o(req_o), .req_slot_o(req_slot_o),
        .ld_valid_i(ld_valid_i), .ld_data_i(ld_data_i), .ld_addr_i(ld_addr_i),
        .dat_o(dat_o), .dat_oe_o(dat_oe_o), .adr_o(adr_o), .adr_oe_o(adr_oe_o),
        .underrun_o(underrun_o), .frame_err_o(frame_err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] pat_data(int f, int s);
        return 16'((f * 16'h1357) ^ (s * 16'h0F21) ^ 16'hA5C3);
    endfunction
    function automatic logic [15:0] pat_addr(int s);
        return 16'((1 << s) | ((s % 2 == 1) ? 16'h8000 : 16'h0000));
    endfunction

    // ---------------- behavioural reference ----------------
    int bitpos = -1;
    int lead_cnt = -1;
    bit m_req = 0;
    int m_rslot = 0;
    bit m_under = 0;
    bit m_ferr = 0;
    bit cur_en = 0;
    logic [15:0] cur_d = 0, cur_a = 0;
    bit have [8];
    logic [15:0] wd [8];
    logic [15:0] wa [8];
    int nslots;

    task automatic slot_start(input int s);
        if (slot_en_i[s] && !have[s]) m_under = 1;
        cur_en = slot_en_i[s];
        cur_d = have[s] ? wd[s] : 16'h0;
        cur_a = have[s] ? wa[s] : 16'h0;
        have[s] = 0;
        if (s + 1 < nslots && slot_en_i[s+1]) begin
            m_req = 1; m_rslot = s + 1;
        end else begin
            m_req = 0;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            bitpos = -1; lead_cnt = -1; m_req = 0; m_rslot = 0;
            m_under = 0; m_ferr = 0; cur_en = 0;
            for (int i = 0; i < 8; i++) have[i] = 0;
        end else begin
            int lead;
            lead = cfg_lead_i ? 2 : 1;
            nslots = (cfg_slots_i == 0) ? 1 : ((cfg_slots_i > 8) ? 8 : int'(cfg_slots_i));
            if (frm_i) begin
                bit ok;
                ok = (lead_cnt < 0) && (bitpos < 0 || (16 * nslots - 1 - bitpos) <= lead);
                if (!ok) begin
                    m_ferr = 1; bitpos = -1;
                end else if (bitpos >= 0) begin
                    bitpos++;
                    if (bitpos == 16 * nslots) bitpos = -1;
                end
                lead_cnt = lead;
                m_req = slot_en_i[0];
                m_rslot = 0;
                for (int i = 0; i < 8; i++) have[i] = 0;
            end else begin
                if (m_req && ld_valid_i) begin
                    have[m_rslot] = 1; wd[m_rslot] = ld_data_i; wa[m_rslot] = ld_addr_i;
                    m_req = 0;
                end
                if (bitpos >= 0) begin
                    bitpos++;
                    if (bitpos == 16 * nslots) bitpos = -1;
                end
                if (lead_cnt > 0) begin
                    lead_cnt--;
                    if (lead_cnt == 0) begin
                        bitpos = 0; lead_cnt = -1;
                    end
                end
                if (bitpos >= 0 && bitpos % 16 == 0) slot_start(bitpos / 16);
            end
        end
    end

    // ---------------- compare every cycle, then drive the loader ----------------
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_oe;
            logic e_d, e_a;
            int b;
            e_oe = (bitpos >= 0) && cur_en;
            b = (bitpos >= 0) ? 15 - (bitpos % 16) : 0;
            e_d = e_oe ? cur_d[b] : 1'b0;
            e_a = e_oe ? cur_a[b] : 1'b0;
            chk("R1/R3 data enable", 32'(dat_oe_o), 32'(e_oe));
            chk("R1 data bit", 32'(dat_o), 32'(e_d));
            chk("R2 destination enable", 32'(adr_oe_o), 32'(e_oe));
            chk("R2 destination bit", 32'(adr_o), 32'(e_a));
            chk("R6 request", 32'(req_o), 32'(m_req));
            if (m_req) chk("R6 request slot", 32'(req_slot_o), 32'(m_rslot));
            chk("R7 underrun flag", 32'(underrun_o), 32'(m_under));
            chk("R8 framing flag", 32'(frame_err_o), 32'(m_ferr));
            if (dat_oe_o !== prev_oe)
                chk("R5 enable edge on slot boundary",
                    32'((bitpos < 0) || (bitpos % 16 == 0)), 32'd1);
        end
        prev_oe = dat_oe_o;
        if (auto_load && req_o && !rst) begin
            ld_valid_i <= 1'b1;
            ld_data_i  <= pat_data(frame_id, int'(req_slot_o));
            ld_addr_i  <= pat_addr(int'(req_slot_o));
        end else begin
            ld_valid_i <= 1'b0;
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse();
        @(negedge clk);
        frm_i = 1'b1;
        frame_id++;
        @(negedge clk);
        frm_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired R10 actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        // R10: reset state
        chk("R10 data enable in reset", 32'(dat_oe_o), 0);
        chk("R10 destination enable in reset", 32'(adr_oe_o), 0);
        chk("R10 request in reset", 32'(req_o), 0);
        chk("R10 flags in reset", 32'({underrun_o, frame_err_o}), 0);
        rst = 1'b0;
        idle(3);

        // R1 R9: one-bit lead-in, 4 slots, back-to-back frames
        cfg_lead_i = 1'b0; cfg_slots_i = 4'd4; slot_en_i = 8'b0000_1011;
        for (int f = 0; f < 3; f++) begin
            pulse();
            idle(64 - 2);
        end
        idle(20);
        chk("R4 lines released after last slot", 32'({dat_oe_o, adr_oe_o}), 0);
        chk("R9 no framing error on back-to-back frames", 32'(frame_err_o), 0);

        // R4 R9: two-bit lead-in, over-range slot count clamps to 8
        cfg_lead_i = 1'b1; cfg_slots_i = 4'd15; slot_en_i = 8'hA5;
        for (int f = 0; f < 3; f++) begin
            pulse();
            idle(128 - 2);
        end
        idle(10);
        chk("R9 two-bit lead back-to-back", 32'(frame_err_o), 0);

        // R4: slot count 0 means a single slot, all owned
        cfg_lead_i = 1'b0; cfg_slots_i = 4'd0; slot_en_i = 8'hFF;
        pulse(); idle(16 - 2);
        pulse(); idle(30);
        chk("R4 single-slot frame then idle", 32'(dat_oe_o), 0);

        // R7: no producer, owned slots send zeros
        auto_load = 1'b0;
        cfg_slots_i = 4'd2; slot_en_i = 8'b0000_0011;
        pulse(); idle(10);
        chk("R7 underrun raised", 32'(underrun_o), 1);
        chk("R7 enable kept in starved slot", 32'(dat_oe_o), 1);
        idle(40);
        auto_load = 1'b1;

        // R8: pulse in the middle of slot 1
        cfg_slots_i = 4'd4; slot_en_i = 8'h0F;
        pulse(); idle(20);
        pulse(); idle(2);
        chk("R8 framing error mid-slot", 32'(frame_err_o), 1);
        idle(80);

        // R8: pulse during the two-bit lead-in
        cfg_lead_i = 1'b1;
        rst = 1'b1; idle(2); rst = 1'b0;
        chk("R10 flags cleared by reset", 32'({underrun_o, frame_err_o}), 0);
        pulse(); pulse(); idle(1);
        chk("R8 framing error in lead-in", 32'(frame_err_o), 1);
        idle(80);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule